// File: doc/BRIEF.md
# Auto-Baud Rate Detector and Bit-Tick Generator

This block listens to an asynchronous single-wire serial line and works out the bit rate of a host that sends one known calibration character. It passes the line through a synchronizer and edge detector, then times a window that spans eight bit periods of that character. The window's start and end edges depend on which calibration character is selected. When the closing edge arrives, the measured cycle count is divided by eight with rounding to nearest and written straight into the reload register of a bit-rate generator. From then on, the generator emits one single-cycle tick per bit period for the serial engine that follows.

Two calibration characters are supported: 80h, which is the default, and 0Dh. Detection runs only after an arm pulse. A capture or an overflow disarms it, so the rate stays fixed until software arms it again. If the line stays quiet for so long that the measurement counter reaches its ceiling before the closing edge, the attempt is abandoned, an overflow flag is raised, and the previous rate is kept. Framing, data reception and parity belong to other blocks.

Top module: `autobaud_gen`

## Requirements
- R1: After reset, `reload_o` equals the parameter `RST_RELOAD` (0 by default), `done_o` and `ovf_o` are 0, and `tick_o` stays low while the reload value is 0.
- R2: Line edges have no effect unless the block is armed. A one-cycle `arm_i` pulse clears `done_o` and `ovf_o` and starts a fresh hunt for the start edge, even if a measurement is already in progress.
- R3: With `char_sel_i` = 0 (character 80h, LSB first, idle-high line), the window opens on the falling edge of the start bit and closes on the first rising edge after it, which is the edge that begins data bit 7.
- R4: With `char_sel_i` = 1 (character 0Dh), the window opens on the rising edge that ends the start bit and closes on the second rising edge after that, which is the edge that begins the stop bit.
- R5: When the window closes after N clock cycles, `reload_o` becomes (N + 4) >> 3 and `done_o` is set. `reload_o` changes at no other time.
- R6: The counter saturates at 2^CNT_W − 1. If the counter reaches that value without a closing edge, `ovf_o` is set, `done_o` stays 0 and `reload_o` keeps its previous value. A closing edge that arrives in the saturating cycle itself (N = 2^CNT_W − 1) still counts as a successful capture.
- R7: After a capture or an overflow, the block is disarmed, and further characters leave `reload_o`, `done_o` and `ovf_o` unchanged until the next `arm_i` pulse.
- R8: While `reload_o` is nonzero, `tick_o` is a one-cycle pulse that repeats every `reload_o` clock cycles. A new reload value restarts the period.
- R9: `char_sel_i` is sampled at the arm pulse. Changing it during detection does not alter which window is measured.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd_i | input | 1 | Serial line, idle high, asynchronous to clk |
| char_sel_i | input | 1 | Calibration character: 0 selects 80h, 1 selects 0Dh |
| arm_i | input | 1 | One-cycle pulse that starts a detection |
| reload_o | output | CNT_W-2 | Rate generator reload value (clock cycles per bit) |
| tick_o | output | 1 | One-cycle bit-rate tick |
| done_o | output | 1 | A rate has been captured since the last arm |
| ovf_o | output | 1 | The last detection aborted on counter saturation |

## Verification
Two events can meet in one cycle: the measurement counter reaching its ceiling and the closing edge arriving. When they coincide, the capture must win. The bench provokes this with a small counter width by holding an 80h window open for exactly 2^CNT_W − 1 cycles, which must capture with rate 128. It then repeats the window one cycle longer, which must raise the overflow flag and leave the rate at 128. Both outcomes are judged at the ports through `done_o`, `ovf_o`, `reload_o` and the measured tick period.

// File: rtl/abd_pkg.sv
package abd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_HUNT  = 2'd1,
    ST_LEAD  = 2'd2,
    ST_COUNT = 2'd3
  } abd_state_e;

  typedef enum logic {
    CAL_80H = 1'b0,
    CAL_0DH = 1'b1
  } cal_char_e;

  localparam logic [1:0] RISES_80H = 2'd1;
  localparam logic [1:0] RISES_0DH = 2'd2;

endpackage

// File: rtl/abd_sync.sv
module abd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic rise_o,
  output logic fall_o
);

  logic [STAGES:0] sh_q;
  logic [STAGES:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-1:0], line_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '1;
    end else begin
      sh_q <= sh_d;
    end
  end

  always_comb begin
    rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
    fall_o = ~sh_q[STAGES-1] & sh_q[STAGES];
  end

endmodule

// File: rtl/abd_measure.sv
module abd_measure
  import abd_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_i,
  input  logic             sel_i,
  input  logic             rise_i,
  input  logic             fall_i,
  output logic             cap_vld_o,
  output logic [CNT_W-3:0] cap_rate_o,
  output logic             done_o,
  output logic             ovf_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  abd_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [1:0]       left_q, left_d;
  cal_char_e        sel_q, sel_d;
  logic             done_q, done_d;
  logic             ovf_q, ovf_d;
  logic             cap;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    left_d = left_q;
    sel_d  = sel_q;
    done_d = done_q;
    ovf_d  = ovf_q;
    cap    = 1'b0;
    if (arm_i) begin
      st_d   = ST_HUNT;
      sel_d  = cal_char_e'(sel_i);
      done_d = 1'b0;
      ovf_d  = 1'b0;
      cnt_d  = '0;
      left_d = '0;
    end else begin
      unique case (st_q)
        ST_HUNT: begin
          if (fall_i) begin
            if (sel_q == CAL_80H) begin
              st_d   = ST_COUNT;
              cnt_d  = CNT_ONE;
              left_d = RISES_80H;
            end else begin
              st_d = ST_LEAD;
            end
          end
        end
        ST_LEAD: begin
          if (rise_i) begin
            st_d   = ST_COUNT;
            cnt_d  = CNT_ONE;
            left_d = RISES_0DH;
          end
        end
        ST_COUNT: begin
          if (rise_i && (left_q == 2'd1)) begin
            cap    = 1'b1;
            done_d = 1'b1;
            st_d   = ST_IDLE;
          end else if (cnt_q == CNT_MAX) begin
            ovf_d = 1'b1;
            st_d  = ST_IDLE;
          end else begin
            cnt_d = cnt_q + CNT_ONE;
            if (rise_i) begin
              left_d = left_q - 2'd1;
            end
          end
        end
        default: begin
          st_d = ST_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      left_q <= '0;
      sel_q  <= CAL_80H;
      done_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      left_q <= left_d;
      sel_q  <= sel_d;
      done_q <= done_d;
      ovf_q  <= ovf_d;
    end
  end

  // Divide by eight, rounding to nearest: add back bit 2 of the count.
  always_comb begin
    cap_vld_o  = cap;
    cap_rate_o = {1'b0, cnt_q[CNT_W-1:3]} + {{(CNT_W-3){1'b0}}, cnt_q[2]};
    done_o     = done_q;
    ovf_o      = ovf_q;
  end

endmodule

// File: rtl/abd_brg.sv
module abd_brg #(
  parameter int                RW         = 14,
  parameter logic [RW-1:0]     RST_RELOAD = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [RW-1:0] load_val_i,
  output logic [RW-1:0] reload_o,
  output logic          tick_o
);

  localparam logic [RW-1:0] ONE = RW'(1);

  logic [RW-1:0] rld_q, rld_d;
  logic [RW-1:0] cnt_q, cnt_d;
  logic          run;

  always_comb begin
    run   = (rld_q != '0);
    rld_d = rld_q;
    if (load_i) begin
      rld_d = load_val_i;
    end
  end

  always_comb begin
    if (load_i) begin
      cnt_d = load_val_i - ONE;
    end else if (!run) begin
      cnt_d = '0;
    end else if (cnt_q == '0) begin
      cnt_d = rld_q - ONE;
    end else begin
      cnt_d = cnt_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rld_q <= RST_RELOAD;
      cnt_q <= '0;
    end else begin
      rld_q <= rld_d;
      cnt_q <= cnt_d;
    end
  end

  always_comb begin
    reload_o = rld_q;
    tick_o   = run && (cnt_q == '0);
  end

endmodule

// File: rtl/autobaud_gen.sv
module autobaud_gen #(
  parameter int                CNT_W      = 16,
  parameter int                SYNC_N     = 2,
  parameter logic [CNT_W-3:0]  RST_RELOAD = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rxd_i,
  input  logic             char_sel_i,
  input  logic             arm_i,
  output logic [CNT_W-3:0] reload_o,
  output logic             tick_o,
  output logic             done_o,
  output logic             ovf_o
);

  localparam int RLD_W = CNT_W - 2;

  logic             rise;
  logic             fall;
  logic             cap_vld;
  logic [RLD_W-1:0] cap_rate;

  abd_sync #(
    .STAGES (SYNC_N)
  ) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .line_i (rxd_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  abd_measure #(
    .CNT_W (CNT_W)
  ) u_meas (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm_i      (arm_i),
    .sel_i      (char_sel_i),
    .rise_i     (rise),
    .fall_i     (fall),
    .cap_vld_o  (cap_vld),
    .cap_rate_o (cap_rate),
    .done_o     (done_o),
    .ovf_o      (ovf_o)
  );

  abd_brg #(
    .RW         (RLD_W),
    .RST_RELOAD (RST_RELOAD)
  ) u_brg (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (cap_vld),
    .load_val_i (cap_rate),
    .reload_o   (reload_o),
    .tick_o     (tick_o)
  );

endmodule

// File: rtl/abd_chk.sv
module abd_chk #(
  parameter int RW = 14
) (
  input logic          clk,
  input logic          rst_n,
  input logic          arm_i,
  input logic [RW-1:0] reload_o,
  input logic          tick_o,
  input logic          done_o,
  input logic          ovf_o
);

  assert_flags_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && ovf_o));

  assert_tick_needs_rate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |-> (reload_o != '0));

  assert_reload_only_on_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(reload_o) |-> $rose(done_o));

  assert_overflow_keeps_rate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_o) |-> $stable(reload_o));

  assert_arm_clears_flags_R2: assert property (@(posedge clk) disable iff (!rst_n)
    arm_i |=> (!done_o && !ovf_o));

  assert_tick_spacing_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && (reload_o > RW'(1))) |=> (!tick_o || !$stable(reload_o)));

endmodule

bind autobaud_gen abd_chk #(
  .RW (CNT_W - 2)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .arm_i    (arm_i),
  .reload_o (reload_o),
  .tick_o   (tick_o),
  .done_o   (done_o),
  .ovf_o    (ovf_o)
);

// File: tb/autobaud_gen_tb.sv
module autobaud_gen_tb;

  localparam int CNT_W = 10;
  localparam int RW    = CNT_W - 2;

  logic          clk;
  logic          rst_n;
  logic          rxd;
  logic          sel;
  logic          arm;
  logic [RW-1:0] reload;
  logic          tick;
  logic          done;
  logic          ovf;

  int checks;
  int fails;

  autobaud_gen #(
    .CNT_W (CNT_W)
  ) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .rxd_i      (rxd),
    .char_sel_i (sel),
    .arm_i      (arm),
    .reload_o   (reload),
    .tick_o     (tick),
    .done_o     (done),
    .ovf_o      (ovf)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct packed {
    logic        csel;
    logic [11:0] len;
    logic [7:0]  exp;
  } vec_t;

  // csel 0: 80h window held low for len cycles; csel 1: 0Dh sent with bit time len/8.
  localparam vec_t VECS [7] = '{
    '{1'b0, 12'd80,  8'd10},
    '{1'b0, 12'd83,  8'd10},
    '{1'b0, 12'd84,  8'd11},
    '{1'b1, 12'd96,  8'd12},
    '{1'b0, 12'd200, 8'd25},
    '{1'b1, 12'd56,  8'd7},
    '{1'b0, 12'd9,   8'd1}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_arm(input logic s);
    @(negedge clk);
    sel = s;
    arm = 1'b1;
    @(negedge clk);
    arm = 1'b0;
  endtask

  task automatic line_low(input int len);
    @(negedge clk);
    rxd = 1'b0;
    repeat (len) @(negedge clk);
    rxd = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic send_char(input logic [7:0] c, input int b);
    @(negedge clk);
    rxd = 1'b0;
    repeat (b) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = c[i];
      repeat (b) @(negedge clk);
    end
    rxd = 1'b1;
    repeat (b + 8) @(negedge clk);
  endtask

  task automatic tick_period(output int p);
    int w;
    w = 0;
    p = -1;
    @(negedge clk);
    while (!tick && w < 3000) begin
      @(negedge clk);
      w++;
    end
    if (tick) begin
      p = 0;
      do begin
        @(negedge clk);
        p++;
      end while (!tick && p < 3000);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int p;
    int ticks;
    checks = 0;
    fails  = 0;
    rxd    = 1'b1;
    sel    = 1'b0;
    arm    = 1'b0;
    rst_n  = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state, no ticks with a zero rate
    @(negedge clk);
    chk("R1 reload", int'(reload), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 ovf", int'(ovf), 0);
    ticks = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (tick) ticks++;
    end
    chk("R1 R8 no tick at zero rate", ticks, 0);

    // R2: edges ignored while not armed
    line_low(80);
    chk("R2 unarmed reload", int'(reload), 0);
    chk("R2 unarmed done", int'(done), 0);

    // R3 R4 R5 R8: table of characters
    for (int v = 0; v < 7; v++) begin
      do_arm(VECS[v].csel);
      if (VECS[v].csel == 1'b0) line_low(int'(VECS[v].len));
      else send_char(8'h0D, int'(VECS[v].len) / 8);
      chk(VECS[v].csel ? "R4 done" : "R3 done", int'(done), 1);
      chk("R5 ovf clear", int'(ovf), 0);
      chk("R5 reload", int'(reload), int'(VECS[v].exp));
      tick_period(p);
      chk("R8 tick period", p, int'(VECS[v].exp));
    end

    // R7: disarmed after capture
    line_low(40);
    chk("R7 reload kept after capture", int'(reload), 1);

    // R9: selection latched at arm
    do_arm(1'b0);
    sel = 1'b1;
    line_low(120);
    chk("R9 latched select done", int'(done), 1);
    chk("R9 latched select reload", int'(reload), 15);

    // R2: re-arm in the middle of a window restarts the hunt
    do_arm(1'b0);
    @(negedge clk);
    rxd = 1'b0;
    repeat (30) @(negedge clk);
    arm = 1'b1;
    @(negedge clk);
    arm = 1'b0;
    repeat (10) @(negedge clk);
    rxd = 1'b1;
    repeat (8) @(negedge clk);
    chk("R2 rearm no capture", int'(done), 0);
    chk("R2 rearm reload kept", int'(reload), 15);
    line_low(64);
    chk("R2 rearm then capture", int'(reload), 8);

    // R6: closing edge on the saturating cycle still captures
    do_arm(1'b0);
    line_low(1023);
    chk("R6 saturating edge done", int'(done), 1);
    chk("R6 saturating edge ovf", int'(ovf), 0);
    chk("R6 saturating edge reload", int'(reload), 128);

    // R6: one cycle longer overflows
    do_arm(1'b0);
    line_low(1024);
    chk("R6 overflow flag", int'(ovf), 1);
    chk("R6 overflow done", int'(done), 0);
    chk("R6 overflow reload kept", int'(reload), 128);
    tick_period(p);
    chk("R8 period after overflow", p, 128);

    // R7: disarmed after overflow
    line_low(40);
    chk("R7 ovf held", int'(ovf), 1);
    chk("R7 reload kept after overflow", int'(reload), 128);

    // R2: arm clears overflow
    do_arm(1'b0);
    @(negedge clk);
    chk("R2 arm clears ovf", int'(ovf), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule